// File: doc/BRIEF.md
# Exception Cause Dispatch Unit

This unit sits beside a processor pipeline and records the architectural state of a trap. When the pipeline raises a general exception it supplies the faulting program counter, a cause code and, optionally, a faulting virtual address. The unit saves that information into its exception registers, marks the processor as being inside an exception, and reports which vector the fetch logic must jump to (kernel, user, double or debug) together with a one-cycle redirect strobe.

Debug exceptions arrive on a separate request. One is accepted only when the current interrupt level is below the configured debug level. An accepted debug exception saves the program counter and the old status into the per-level registers of that debug level. It then raises the interrupt level to the debug level. If a general exception and a debug exception arrive together, the general exception is served first and the debug exception is held for one cycle.

Software reads and writes every saved register through a simple address/data port. A return-from-exception input clears the in-exception flag. Request inputs are sampled on a rising clock edge, and the redirect strobe and vector code are registered, so they appear in the cycle after the request.

Top module: `trap_dispatch`

## Requirements
- R1: After reset every register reads zero, `redirect` is 0 and `vecSel` is 0.
- R2: The status register holds the interrupt level in bits [3:0], the in-exception flag in bit 4 and the user-mode flag in bit 5. A general request taken while the in-exception flag is clear stores the PC in the level-1 saved-PC register. The cycle after the request, `redirect` is 1 for exactly one cycle and `vecSel` is 1 (kernel) if the user-mode flag is 0, or 2 (user) if it is 1.
- R3: A general request taken while the in-exception flag is set gives `vecSel` 3 (double). The PC goes to the double-exception PC register when `HAS_DPC` is 1. When `HAS_DPC` is 0 it goes to the level-1 saved-PC register, and the double-exception PC register stays zero.
- R4: Every general request writes the cause code into the cause register and sets the in-exception flag. The interrupt level and the user-mode flag are left unchanged.
- R5: A general request with `excHasAddr`=1 stores `excAddr` in the virtual-address register. With `excHasAddr`=0 that register keeps its value.
- R6: A debug request is taken only when the interrupt level is strictly below `DBG_LEVEL`. Otherwise it is dropped: there is no redirect and no register changes.
- R7: A taken debug request writes the debug-cause register. It stores the PC in the saved-PC register of level `DBG_LEVEL` and copies the old status into the saved-status register of that level. It then sets the interrupt level to `DBG_LEVEL` and sets the in-exception flag, leaving the user-mode flag alone. `vecSel` is 4 (debug).
- R8: When a general and a debug request arrive in the same cycle, the general one is served. The debug request is held and served in the next cycle that has no general request. A new debug request that arrives while one is held is ignored.
- R9: A pulse on `rfe` clears only the in-exception flag and produces no redirect.
- R10: Software addresses: 0x00 status, 0x01 cause, 0x02 virtual address, 0x03 double-exception PC, 0x04 debug cause, 0x08+L saved PC of level L (1..`DBG_LEVEL`), and 0x10+L saved status of level L (2..`DBG_LEVEL`). A write updates the register on the next edge, and a read returns it combinationally. A status write keeps bits [5:0].
- R11: Unmapped addresses, and the double-exception PC address when `HAS_DPC` is 0, read zero and ignore writes. Whenever `redirect` is 0, `vecSel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| excReq | input | 1 | General exception request |
| excPc | input | XLEN | Faulting PC of the general request |
| excCause | input | CAUSE_W | Cause code of the general request |
| excHasAddr | input | 1 | Request carries a faulting address |
| excAddr | input | XLEN | Faulting virtual address |
| dbgReq | input | 1 | Debug exception request |
| dbgPc | input | XLEN | PC of the debug request |
| dbgCause | input | DCAUSE_W | Debug cause code |
| rfe | input | 1 | Return from exception, clears the in-exception flag |
| swWrEn | input | 1 | Software write strobe |
| swAddr | input | 5 | Software register address |
| swWrData | input | XLEN | Software write data |
| swRdData | output | XLEN | Software read data |
| vecSel | output | 3 | Selected vector: 0 none, 1 kernel, 2 user, 3 double, 4 debug |
| redirect | output | 1 | One-cycle strobe for a taken exception |

## Verification
The assertions assume that a software write never targets a register that a hardware event updates in the same cycle. They also assume that `rfe` is not pulsed in a cycle that carries an exception. The stimulus respects both assumptions by running each software write, request and `rfe` pulse in its own clock cycle. Two exceptions come together only in the dedicated same-cycle test. The sweeps cover every 6-bit status value for general requests and every interrupt level with both user-mode settings for debug requests. Two instances, one with and one without the double-exception PC register, receive the same inputs.

// File: rtl/trap_pkg.sv
`timescale 1ns/1ps
package trap_pkg;
  typedef enum logic [2:0] {
    VEC_NONE   = 3'd0,
    VEC_KERNEL = 3'd1,
    VEC_USER   = 3'd2,
    VEC_DOUBLE = 3'd3,
    VEC_DEBUG  = 3'd4
  } vec_e;

  typedef struct packed {
    logic wrVaddr;
    logic wrCause;
    logic wrEpc1;
    logic wrDepc;
    logic setExcm;
    logic clrExcm;
    logic dbgTake;
  } strobe_t;

  localparam int ILVL_W  = 4;
  localparam int ST_EXCM = 4;
  localparam int ST_UM   = 5;
  localparam int ST_W    = 6;
  localparam int AW      = 5;

  localparam logic [AW-1:0] A_STATUS   = 5'h00;
  localparam logic [AW-1:0] A_CAUSE    = 5'h01;
  localparam logic [AW-1:0] A_VADDR    = 5'h02;
  localparam logic [AW-1:0] A_DEPC     = 5'h03;
  localparam logic [AW-1:0] A_DBGCAUSE = 5'h04;
  localparam logic [AW-1:0] A_EPC_BASE = 5'h08;
  localparam logic [AW-1:0] A_EPS_BASE = 5'h10;
endpackage

// File: rtl/trap_ctrl.sv
`timescale 1ns/1ps
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int DCAUSE_W  = 6,
  parameter int DBG_LEVEL = 3,
  parameter bit HAS_DPC   = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                excReq,
  input  logic                excHasAddr,
  input  logic                dbgReq,
  input  logic [XLEN-1:0]     dbgPc,
  input  logic [DCAUSE_W-1:0] dbgCause,
  input  logic                rfe,
  input  logic [ST_W-1:0]     statusQ,
  output strobe_t             strb,
  output logic [XLEN-1:0]     dbgPcSel,
  output logic [DCAUSE_W-1:0] dbgCauseSel,
  output logic                redirect,
  output vec_e                vecSel
);
  localparam logic [ILVL_W-1:0] DBG_LVL_V = ILVL_W'(DBG_LEVEL);

  logic                pendQ;
  logic [XLEN-1:0]     pendPcQ;
  logic [DCAUSE_W-1:0] pendCauseQ;
  logic                dbgAvail, gateOk, inExc;
  vec_e                vecNext;

  assign dbgAvail    = pendQ | dbgReq;
  assign dbgPcSel    = pendQ ? pendPcQ : dbgPc;
  assign dbgCauseSel = pendQ ? pendCauseQ : dbgCause;
  assign gateOk      = statusQ[ILVL_W-1:0] < DBG_LVL_V;
  assign inExc       = statusQ[ST_EXCM];

  always_comb begin
    strb         = '0;
    strb.wrVaddr = excReq & excHasAddr;
    strb.wrCause = excReq;
    strb.setExcm = excReq;
    strb.wrDepc  = excReq & inExc & HAS_DPC;
    strb.wrEpc1  = excReq & ~(inExc & HAS_DPC);
    strb.clrExcm = rfe;
    strb.dbgTake = dbgAvail & ~excReq & gateOk;
  end

  always_comb begin
    if (excReq) begin
      if (inExc)                vecNext = VEC_DOUBLE;
      else if (statusQ[ST_UM])  vecNext = VEC_USER;
      else                      vecNext = VEC_KERNEL;
    end else if (strb.dbgTake) begin
      vecNext = VEC_DEBUG;
    end else begin
      vecNext = VEC_NONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ      <= 1'b0;
      pendPcQ    <= '0;
      pendCauseQ <= '0;
      redirect   <= 1'b0;
      vecSel     <= VEC_NONE;
    end else begin
      redirect <= (vecNext != VEC_NONE);
      vecSel   <= vecNext;
      if (dbgAvail && excReq) begin
        pendQ <= 1'b1;
        if (!pendQ) begin
          pendPcQ    <= dbgPc;
          pendCauseQ <= dbgCause;
        end
      end else begin
        pendQ <= 1'b0;
      end
    end
  end

  // R3: a double vector follows only from a request made while in an exception
  a_r3_double_needs_excm: assert property (@(posedge clk) disable iff (!rstN)
    (redirect && vecSel == VEC_DOUBLE) |-> ($past(excReq) && $past(statusQ[ST_EXCM])));
  // R6: a debug vector follows only from a level below the debug level
  a_r6_debug_gate: assert property (@(posedge clk) disable iff (!rstN)
    (redirect && vecSel == VEC_DEBUG) |-> ($past(statusQ[ILVL_W-1:0]) < DBG_LVL_V));
  // R8: a colliding debug request is held for the next cycle
  a_r8_hold_debug: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && dbgReq && !pendQ) |=> pendQ);
  // R11: idle vector code is zero
  a_r11_idle_none: assert property (@(posedge clk) disable iff (!rstN)
    !redirect |-> (vecSel == VEC_NONE));
endmodule

// File: rtl/trap_regs.sv
`timescale 1ns/1ps
module trap_regs
  import trap_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 6,
  parameter int DCAUSE_W  = 6,
  parameter int DBG_LEVEL = 3,
  parameter bit HAS_DPC   = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [XLEN-1:0]     excPc,
  input  logic [CAUSE_W-1:0]  excCause,
  input  logic [XLEN-1:0]     excAddr,
  input  logic [XLEN-1:0]     dbgPc,
  input  logic [DCAUSE_W-1:0] dbgCause,
  input  logic                swWrEn,
  input  logic [AW-1:0]       swAddr,
  input  logic [XLEN-1:0]     swWrData,
  output logic [ST_W-1:0]     statusQ,
  output logic [XLEN-1:0]     swRdData
);
  localparam logic [ILVL_W-1:0] DBG_LVL_V = ILVL_W'(DBG_LEVEL);

  logic [ST_W-1:0]     statusNext;
  logic [CAUSE_W-1:0]  causeQ;
  logic [DCAUSE_W-1:0] dbgCauseQ;
  logic [XLEN-1:0]     vaddrQ, depcQ;
  logic [XLEN-1:0]     epcQ [1:DBG_LEVEL];
  logic [ST_W-1:0]     epsQ [2:DBG_LEVEL];

  function automatic logic swHit(input logic [AW-1:0] a);
    return swWrEn && (swAddr == a);
  endfunction

  always_comb begin
    statusNext = statusQ;
    if (swHit(A_STATUS)) statusNext = swWrData[ST_W-1:0];
    if (strb.clrExcm)    statusNext[ST_EXCM] = 1'b0;
    if (strb.setExcm)    statusNext[ST_EXCM] = 1'b1;
    if (strb.dbgTake) begin
      statusNext[ILVL_W-1:0] = DBG_LVL_V;
      statusNext[ST_EXCM]    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ   <= '0;
      causeQ    <= '0;
      dbgCauseQ <= '0;
      vaddrQ    <= '0;
      for (int l = 1; l <= DBG_LEVEL; l++) epcQ[l] <= '0;
      for (int l = 2; l <= DBG_LEVEL; l++) epsQ[l] <= '0;
    end else begin
      statusQ <= statusNext;
      if (strb.wrCause)          causeQ <= excCause;
      else if (swHit(A_CAUSE))   causeQ <= swWrData[CAUSE_W-1:0];
      if (strb.wrVaddr)          vaddrQ <= excAddr;
      else if (swHit(A_VADDR))   vaddrQ <= swWrData;
      if (strb.dbgTake)          dbgCauseQ <= dbgCause;
      else if (swHit(A_DBGCAUSE)) dbgCauseQ <= swWrData[DCAUSE_W-1:0];
      for (int l = 1; l <= DBG_LEVEL; l++) begin
        if (l == 1 && strb.wrEpc1)                epcQ[l] <= excPc;
        else if (l == DBG_LEVEL && strb.dbgTake)  epcQ[l] <= dbgPc;
        else if (swHit(A_EPC_BASE + AW'(l)))      epcQ[l] <= swWrData;
      end
      for (int l = 2; l <= DBG_LEVEL; l++) begin
        if (l == DBG_LEVEL && strb.dbgTake)       epsQ[l] <= statusQ;
        else if (swHit(A_EPS_BASE + AW'(l)))      epsQ[l] <= swWrData[ST_W-1:0];
      end
    end
  end

  generate
    if (HAS_DPC) begin : g_depc
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              depcQ <= '0;
        else if (strb.wrDepc)   depcQ <= excPc;
        else if (swHit(A_DEPC)) depcQ <= swWrData;
      end
    end else begin : g_no_depc
      assign depcQ = '0;
    end
  endgenerate

  always_comb begin
    swRdData = '0;
    case (swAddr)
      A_STATUS:   swRdData = XLEN'(statusQ);
      A_CAUSE:    swRdData = XLEN'(causeQ);
      A_VADDR:    swRdData = vaddrQ;
      A_DEPC:     swRdData = depcQ;
      A_DBGCAUSE: swRdData = XLEN'(dbgCauseQ);
      default:    swRdData = '0;
    endcase
    for (int l = 1; l <= DBG_LEVEL; l++)
      if (swAddr == A_EPC_BASE + AW'(l)) swRdData = epcQ[l];
    for (int l = 2; l <= DBG_LEVEL; l++)
      if (swAddr == A_EPS_BASE + AW'(l)) swRdData = XLEN'(epsQ[l]);
  end

  // R4: a general exception leaves the in-exception flag set
  a_r4_excm_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.setExcm |=> statusQ[ST_EXCM]);
  // R7: a taken debug exception raises the level to the debug level
  a_r7_debug_level: assert property (@(posedge clk) disable iff (!rstN)
    strb.dbgTake |=> (statusQ[ILVL_W-1:0] == DBG_LVL_V && statusQ[ST_EXCM]));
  // R9: return from exception clears the flag when nothing else writes status
  a_r9_rfe_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrExcm && !strb.setExcm && !strb.dbgTake && !swHit(A_STATUS))
      |=> !statusQ[ST_EXCM]);
  // R5: virtual address holds without a writer
  a_r5_vaddr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrVaddr && !swHit(A_VADDR)) |=> $stable(vaddrQ));
endmodule

// File: rtl/trap_dispatch.sv
`timescale 1ns/1ps
module trap_dispatch
  import trap_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 6,
  parameter int DCAUSE_W  = 6,
  parameter int DBG_LEVEL = 3,
  parameter bit HAS_DPC   = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                excReq,
  input  logic [XLEN-1:0]     excPc,
  input  logic [CAUSE_W-1:0]  excCause,
  input  logic                excHasAddr,
  input  logic [XLEN-1:0]     excAddr,
  input  logic                dbgReq,
  input  logic [XLEN-1:0]     dbgPc,
  input  logic [DCAUSE_W-1:0] dbgCause,
  input  logic                rfe,
  input  logic                swWrEn,
  input  logic [4:0]          swAddr,
  input  logic [XLEN-1:0]     swWrData,
  output logic [XLEN-1:0]     swRdData,
  output logic [2:0]          vecSel,
  output logic                redirect
);
  strobe_t             strb;
  logic [ST_W-1:0]     statusQ;
  logic [XLEN-1:0]     dbgPcSel;
  logic [DCAUSE_W-1:0] dbgCauseSel;
  vec_e                vecQ;

  trap_ctrl #(.XLEN(XLEN), .DCAUSE_W(DCAUSE_W), .DBG_LEVEL(DBG_LEVEL), .HAS_DPC(HAS_DPC)) u_ctrl (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excHasAddr(excHasAddr),
    .dbgReq(dbgReq), .dbgPc(dbgPc), .dbgCause(dbgCause), .rfe(rfe),
    .statusQ(statusQ), .strb(strb), .dbgPcSel(dbgPcSel), .dbgCauseSel(dbgCauseSel),
    .redirect(redirect), .vecSel(vecQ)
  );

  trap_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .DCAUSE_W(DCAUSE_W),
              .DBG_LEVEL(DBG_LEVEL), .HAS_DPC(HAS_DPC)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .excPc(excPc), .excCause(excCause),
    .excAddr(excAddr), .dbgPc(dbgPcSel), .dbgCause(dbgCauseSel),
    .swWrEn(swWrEn), .swAddr(swAddr), .swWrData(swWrData),
    .statusQ(statusQ), .swRdData(swRdData)
  );

  assign vecSel = vecQ;
endmodule

// File: tb/trap_dispatch_test.sv
`timescale 1ns/1ps
module trap_dispatch_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic excReq = 0, excHasAddr = 0, dbgReq = 0, rfe = 0, swWrEn = 0;
  logic [31:0] excPc = 0, excAddr = 0, dbgPc = 0, swWrData = 0;
  logic [5:0] excCause = 0, dbgCause = 0;
  logic [4:0] swAddr = 0;
  logic [31:0] rdA, rdB;
  logic [2:0] vecA, vecB;
  logic redA, redB;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trap_dispatch #(.DBG_LEVEL(3), .HAS_DPC(1'b1)) uut (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excPc(excPc), .excCause(excCause),
    .excHasAddr(excHasAddr), .excAddr(excAddr), .dbgReq(dbgReq), .dbgPc(dbgPc),
    .dbgCause(dbgCause), .rfe(rfe), .swWrEn(swWrEn), .swAddr(swAddr),
    .swWrData(swWrData), .swRdData(rdA), .vecSel(vecA), .redirect(redA));

  trap_dispatch #(.DBG_LEVEL(3), .HAS_DPC(1'b0)) uutNd (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excPc(excPc), .excCause(excCause),
    .excHasAddr(excHasAddr), .excAddr(excAddr), .dbgReq(dbgReq), .dbgPc(dbgPc),
    .dbgCause(dbgCause), .rfe(rfe), .swWrEn(swWrEn), .swAddr(swAddr),
    .swWrData(swWrData), .swRdData(rdB), .vecSel(vecB), .redirect(redB));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] va, output logic [31:0] vb);
    swAddr = a;
    #0.2;
    va = rdA;
    vb = rdB;
  endtask

  task automatic swWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    swWrEn = 1; swAddr = a; swWrData = d;
    @(posedge clk); #1;
    swWrEn = 0;
  endtask

  task automatic genExc(input logic [31:0] pc, input logic [5:0] c, input logic ha, input logic [31:0] ad);
    @(negedge clk);
    excReq = 1; excPc = pc; excCause = c; excHasAddr = ha; excAddr = ad;
    @(posedge clk); #1;
    excReq = 0; excHasAddr = 0;
  endtask

  task automatic dbgExc(input logic [31:0] pc, input logic [5:0] c);
    @(negedge clk);
    dbgReq = 1; dbgPc = pc; dbgCause = c;
    @(posedge clk); #1;
    dbgReq = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] a, b, pc, ad, mVaddr, mEpc1, mEpc1Nd, mDepc, mEpc3, mEps3, mDcause;
    logic [5:0] st, c;
    logic [2:0] ev;
    logic took;
    mVaddr = 0; mEpc1 = 0; mEpc1Nd = 0; mDepc = 0; mEpc3 = 0; mEps3 = 0; mDcause = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    check("R1 redirect", {31'b0, redA}, 0);
    check("R1 vecSel", {29'b0, vecA}, 0);
    for (int r = 0; r < 32; r++) begin
      rd(r[4:0], a, b);
      check("R1 reg zero", a, 0);
    end
    @(negedge clk); rstN = 1;

    // R2 R3 R4 R5 sweep over every status value
    for (int s = 0; s < 64; s++) begin
      st = s[5:0];
      pc = 32'h4000_0000 + s * 32'h0000_0104;
      ad = ~pc ^ 32'h0F0F_0000;
      c = st ^ 6'h2A;
      swWrite(5'h00, {26'b0, st});
      genExc(pc, c, st[0], ad);
      ev = st[4] ? 3'd3 : (st[5] ? 3'd2 : 3'd1);
      check("R2 redirect", {31'b0, redA}, 1);
      check("R2 R3 vecSel", {29'b0, vecA}, {29'b0, ev});
      check("R3 vecSel no-dpc", {29'b0, vecB}, {29'b0, ev});
      if (st[4]) begin mDepc = pc; mEpc1Nd = pc; end
      else begin mEpc1 = pc; mEpc1Nd = pc; end
      if (st[0]) mVaddr = ad;
      rd(5'h00, a, b); check("R4 status", a, {26'b0, st | 6'h10});
      rd(5'h01, a, b); check("R4 cause", a, {26'b0, c});
      rd(5'h02, a, b); check("R5 vaddr", a, mVaddr);
      rd(5'h09, a, b); check("R2 epc1", a, mEpc1); check("R3 epc1 no-dpc", b, mEpc1Nd);
      rd(5'h03, a, b); check("R3 depc", a, mDepc); check("R3 depc absent", b, 0);
    end

    // R2 strobe lasts one cycle
    swWrite(5'h00, 32'h0);
    genExc(32'h100, 6'h1, 0, 0);
    @(posedge clk); #1;
    check("R2 one-cycle redirect", {31'b0, redA}, 0);
    check("R11 idle vecSel", {29'b0, vecA}, 0);

    // R6 R7 debug sweep
    for (int s = 0; s < 32; s++) begin
      st = {s[4], s[0], s[3:0]};
      pc = 32'h8000_0010 + s * 32'h20;
      c = 6'(s + 5);
      swWrite(5'h00, {26'b0, st});
      dbgExc(pc, c);
      took = (st[3:0] < 4'd3);
      check("R6 debug redirect", {31'b0, redA}, {31'b0, took});
      check("R6 R7 debug vec", {29'b0, vecA}, took ? 32'd4 : 32'd0);
      if (took) begin mEpc3 = pc; mEps3 = {26'b0, st}; mDcause = {26'b0, c}; end
      rd(5'h00, a, b);
      check("R6 R7 status", a, took ? {26'b0, st[5], 1'b1, 4'd3} : {26'b0, st});
      rd(5'h0B, a, b); check("R7 epc level3", a, mEpc3);
      rd(5'h13, a, b); check("R7 eps level3", a, mEps3);
      rd(5'h04, a, b); check("R7 debug cause", a, mDcause);
    end

    // R8 simultaneous requests
    swWrite(5'h00, 32'h0);
    @(negedge clk);
    excReq = 1; excPc = 32'hA000_0000; excCause = 6'h07;
    dbgReq = 1; dbgPc = 32'hB000_0000; dbgCause = 6'h11;
    @(posedge clk); #1;
    excReq = 0;
    check("R8 general first", {29'b0, vecA}, 1);
    dbgPc = 32'hC000_0000; dbgCause = 6'h22;
    @(posedge clk); #1;
    dbgReq = 0;
    check("R8 held debug served", {29'b0, vecA}, 4);
    rd(5'h0B, a, b); check("R8 held pc", a, 32'hB000_0000);
    rd(5'h04, a, b); check("R8 second debug ignored", a, 32'h11);
    @(posedge clk); #1;
    check("R8 no extra redirect", {31'b0, redA}, 0);

    // R9 return from exception
    swWrite(5'h00, 32'h3F);
    @(negedge clk); rfe = 1;
    @(posedge clk); #1; rfe = 0;
    check("R9 no redirect", {31'b0, redA}, 0);
    rd(5'h00, a, b); check("R9 status", a, 32'h2F);

    // R10 R11 software map
    swWrite(5'h00, 32'hFFFF_FFC5);
    rd(5'h00, a, b); check("R10 status bits", a, 32'h05);
    swWrite(5'h0A, 32'h1234_5678);
    rd(5'h0A, a, b); check("R10 epc level2", a, 32'h1234_5678);
    swWrite(5'h12, 32'hFFFF_FFFF);
    rd(5'h12, a, b); check("R10 eps level2", a, 32'h3F);
    swWrite(5'h0D, 32'hDEAD_BEEF);
    rd(5'h0D, a, b); check("R11 unmapped epc level5", a, 0);
    swWrite(5'h11, 32'hDEAD_BEEF);
    rd(5'h11, a, b); check("R11 unmapped eps level1", a, 0);
    swWrite(5'h03, 32'hCAFE_0001);
    rd(5'h03, a, b);
    check("R10 depc write", a, 32'hCAFE_0001);
    check("R11 depc absent write", b, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule